// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface. It drives the clock-enable, on-die-termination, command, bank-address and address pins from the moment reset is released until the memory is ready for normal traffic. During that time it walks the mandatory bring-up order. First it holds CKE low while the clock settles. It then raises CKE and idles on NOPs. Two all-bank precharges follow, with four mode-register writes between them: the DLL-reset write is the last of the four. Next come a burst of auto-refreshes and the final mode write. The sequence closes with an OCD-default / OCD-exit pair of extended writes. After that the block raises `ready`, and it keeps `ready` high until the next reset.

Every wait is a parameter counted in controller clocks. One down-counter is reloaded on entry to each step. A second counter enforces the minimum distance between the DLL-reset write and the OCD-default write. The operating mode words come in on input ports and must be stable while the sequence runs. The block itself forces the DLL-enable, DLL-reset and OCD fields of those words.

Top module: `ddr2_boot_seq`

## Requirements
- R1: A synchronous reset, at any point, forces cke=0, odt=0, NOP pins, ba=0, addr=0 and ready=0, and restarts the whole sequence.
- R2: After reset release, cke stays low for exactly T_PWR cycles and then rises. It then stays high for the rest of the run. While cke is low, and for T_NOP cycles after it rises, only NOP is driven.
- R3: Pins are {cs_n,ras_n,cas_n,we_n}: NOP=0111, precharge=0010, refresh=0001, mode write=0000. The first precharge-all (addr bit 10 high, other bits 0, ba=0) comes at cycle T_PWR+T_NOP. The next command follows T_RP cycles later.
- R4: The mode writes go out in a fixed order, each T_MRD cycles after the previous one. The order and bank selects are: ba=2 with emr2_word passed unchanged, then ba=3 with emr3_word passed unchanged, then ba=1, then ba=0.
- R5: The first ba=1 write carries emr1_word with bit 0 cleared (DLL on) and bits 9:7 cleared.
- R6: The ba=0 write in that group carries mr_word with bit 8 (DLL reset) set.
- R7: A second precharge-all comes T_MRD after the DLL-reset write. After a further T_RP cycles, N_REF refresh commands follow, spaced T_RFC apart.
- R8: T_RFC after the last refresh, a final ba=0 write carries mr_word with bit 8 cleared.
- R9: The OCD-default write (ba=1, emr1_word with bit 0 cleared and bits 9:7 = 111) comes at the later of two cycles: the final mode write plus T_MRD, and the DLL-reset write plus T_DLL.
- R10: T_MRD after the OCD-default write, the OCD-exit write follows (ba=1, emr1_word with bit 0 and bits 9:7 cleared). T_MRD after that, ready rises and stays high with NOP pins.
- R11: odt is low on every cycle. Every cycle without a command drives NOP with ba=0 and addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| mr_word | input | ROW_W | Operating main mode word |
| emr1_word | input | ROW_W | Operating extended word for bank select 1 |
| emr2_word | input | ROW_W | Extended word for bank select 2 |
| emr3_word | input | ROW_W | Extended word for bank select 3 |
| cke | output | 1 | Clock enable to memory |
| odt | output | 1 | On-die termination, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address / mode register select |
| addr | output | ROW_W | Address / mode word |
| ready | output | 1 | Initialization complete |

## Verification
The assertions check several rules on every cycle:
- no command goes out while CKE is low;
- CKE never falls again;
- mode writes are at least T_MRD apart;
- refreshes are at least T_RFC apart;
- no OCD-default write comes earlier than T_DLL cycles after the DLL-reset write;
- ready, once high, stays high with NOP pins.

The exact cycle of each command, the fixed order of the writes, and the forcing of the DLL and OCD bits into the mode words can only be shown by the bench's scenarios. The same holds for a restart after a reset in the middle of the sequence. The bench compares every pin on every cycle against a schedule it computes from the parameters. It does so for several mode-word patterns, one of them interrupted by a reset during the refresh phase. The bench configuration makes the DLL distance the longer wait, so the gating of the OCD-default write is exercised.

// File: rtl/ddr2_boot_pkg.sv
package ddr2_boot_pkg;

  typedef enum logic [3:0] {
    ST_PWR, ST_CKE, ST_PRE1, ST_EMR2, ST_EMR3, ST_EMR1, ST_MRDLL,
    ST_PRE2, ST_REF, ST_MRFIN, ST_OCDDEF, ST_OCDX, ST_DONE
  } step_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_NOP  = 4'b0111;
  localparam logic [3:0] PIN_PRE  = 4'b0010;
  localparam logic [3:0] PIN_REF  = 4'b0001;
  localparam logic [3:0] PIN_MODE = 4'b0000;

  localparam int BIT_ALLBANK = 10;
  localparam int BIT_DLLRST  = 8;
  localparam int BIT_DLLOFF  = 0;
  localparam int BIT_OCD_LO  = 7;

  localparam logic [2:0] OCD_EXIT = 3'b000;
  localparam logic [2:0] OCD_DFLT = 3'b111;

endpackage

// File: rtl/boot_wait_ctr.sv
module boot_wait_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] rst_val,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= rst_val;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/boot_step_fsm.sv
module boot_step_fsm
  import ddr2_boot_pkg::*;
#(
  parameter int N_REF = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wait_zero,
  input  logic  gap_ok,
  output step_t step,
  output step_t next_step,
  output logic  fire,
  output logic  count_en,
  output logic  advance
);
  localparam int RW = (N_REF > 1) ? $clog2(N_REF) : 1;

  step_t         step_q;
  step_t         nxt;
  logic          armed;
  logic [RW-1:0] ref_idx;
  logic          gate;

  // only the OCD-default step can be held back by the DLL distance
  assign gate     = (step_q != ST_OCDDEF) || gap_ok;
  assign fire     = armed && gate && (step_q != ST_DONE);
  assign count_en = fire || !armed;
  assign advance  = wait_zero && count_en && (step_q != ST_DONE);

  always_comb begin
    unique case (step_q)
      ST_PWR:    nxt = ST_CKE;
      ST_CKE:    nxt = ST_PRE1;
      ST_PRE1:   nxt = ST_EMR2;
      ST_EMR2:   nxt = ST_EMR3;
      ST_EMR3:   nxt = ST_EMR1;
      ST_EMR1:   nxt = ST_MRDLL;
      ST_MRDLL:  nxt = ST_PRE2;
      ST_PRE2:   nxt = ST_REF;
      ST_REF:    nxt = (ref_idx == RW'(N_REF - 1)) ? ST_MRFIN : ST_REF;
      ST_MRFIN:  nxt = ST_OCDDEF;
      ST_OCDDEF: nxt = ST_OCDX;
      default:   nxt = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= ST_PWR;
      armed   <= 1'b1;
      ref_idx <= '0;
    end else if (advance) begin
      step_q  <= nxt;
      armed   <= 1'b1;
      ref_idx <= (step_q == ST_REF && nxt == ST_REF) ? ref_idx + 1'b1 : '0;
    end else if (fire) begin
      armed   <= 1'b0;
    end
  end

  assign step      = step_q;
  assign next_step = nxt;
endmodule

// File: rtl/boot_cmd_drive.sv
module boot_cmd_drive
  import ddr2_boot_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  step_t            step,
  input  logic             fire,
  input  logic [ROW_W-1:0] mr_word,
  input  logic [ROW_W-1:0] emr1_word,
  input  logic [ROW_W-1:0] emr2_word,
  input  logic [ROW_W-1:0] emr3_word,
  output logic             cke,
  output logic             odt,
  output logic [3:0]       pins,
  output logic [1:0]       ba,
  output logic [ROW_W-1:0] addr,
  output logic             ready
);
  function automatic logic [ROW_W-1:0] ext1_word(input logic [ROW_W-1:0] w,
                                                 input logic [2:0] ocd);
    logic [ROW_W-1:0] r;
    r = w;
    r[BIT_DLLOFF] = 1'b0;
    r[BIT_OCD_LO +: 3] = ocd;
    return r;
  endfunction

  function automatic logic [ROW_W-1:0] main_word(input logic [ROW_W-1:0] w,
                                                 input logic dll_rst);
    logic [ROW_W-1:0] r;
    r = w;
    r[BIT_DLLRST] = dll_rst;
    return r;
  endfunction

  localparam logic [ROW_W-1:0] ALLBANK = ROW_W'(1) << BIT_ALLBANK;

  assign cke   = (step != ST_PWR);
  assign odt   = 1'b0;
  assign ready = (step == ST_DONE);

  always_comb begin
    pins = PIN_NOP;
    ba   = 2'd0;
    addr = '0;
    if (fire) begin
      unique case (step)
        ST_PRE1, ST_PRE2: begin pins = PIN_PRE;  addr = ALLBANK; end
        ST_REF:           begin pins = PIN_REF; end
        ST_EMR2:   begin pins = PIN_MODE; ba = 2'd2; addr = emr2_word; end
        ST_EMR3:   begin pins = PIN_MODE; ba = 2'd3; addr = emr3_word; end
        ST_EMR1:   begin pins = PIN_MODE; ba = 2'd1; addr = ext1_word(emr1_word, OCD_EXIT); end
        ST_MRDLL:  begin pins = PIN_MODE; ba = 2'd0; addr = main_word(mr_word, 1'b1); end
        ST_MRFIN:  begin pins = PIN_MODE; ba = 2'd0; addr = main_word(mr_word, 1'b0); end
        ST_OCDDEF: begin pins = PIN_MODE; ba = 2'd1; addr = ext1_word(emr1_word, OCD_DFLT); end
        ST_OCDX:   begin pins = PIN_MODE; ba = 2'd1; addr = ext1_word(emr1_word, OCD_EXIT); end
        default:   begin pins = PIN_NOP; end
      endcase
    end
  end
endmodule

// File: rtl/ddr2_boot_seq.sv
module ddr2_boot_seq
  import ddr2_boot_pkg::*;
#(
  parameter int T_PWR = 40000,
  parameter int T_NOP = 80,
  parameter int T_RP  = 3,
  parameter int T_MRD = 2,
  parameter int T_RFC = 26,
  parameter int T_DLL = 200,
  parameter int N_REF = 2,
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] mr_word,
  input  logic [ROW_W-1:0] emr1_word,
  input  logic [ROW_W-1:0] emr2_word,
  input  logic [ROW_W-1:0] emr3_word,
  output logic             cke,
  output logic             odt,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [1:0]       ba,
  output logic [ROW_W-1:0] addr,
  output logic             ready
);
  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_MAX = max_of(max_of(max_of(T_PWR, T_NOP), max_of(T_RP, T_MRD)),
                                max_of(T_RFC, T_DLL));
  localparam int CW = $clog2(T_MAX + 1);

  // cycles from a step's first cycle to the next step's first cycle
  function automatic int span_of(input step_t s);
    case (s)
      ST_PWR:            return T_PWR;
      ST_CKE:            return T_NOP;
      ST_PRE1, ST_PRE2:  return T_RP;
      ST_REF:            return T_RFC;
      ST_DONE:           return 1;
      default:           return T_MRD;
    endcase
  endfunction

  step_t      step, next_step;
  logic       fire, count_en, advance, wait_zero, gap_ok;
  logic       ev_dll_mrs;
  logic [3:0] pins;

  assign ev_dll_mrs = fire && (step == ST_MRDLL);

  boot_step_fsm #(.N_REF(N_REF)) u_fsm (
    .clk(clk), .rst(rst), .wait_zero(wait_zero), .gap_ok(gap_ok),
    .step(step), .next_step(next_step), .fire(fire),
    .count_en(count_en), .advance(advance)
  );

  boot_wait_ctr #(.CW(CW)) u_wait (
    .clk(clk), .rst(rst), .rst_val(CW'(T_PWR - 1)),
    .load(advance), .load_val(CW'(span_of(next_step) - 1)),
    .dec(count_en), .zero(wait_zero)
  );

  boot_wait_ctr #(.CW(CW)) u_gap (
    .clk(clk), .rst(rst), .rst_val('0),
    .load(ev_dll_mrs), .load_val(CW'(T_DLL - 1)),
    .dec(1'b1), .zero(gap_ok)
  );

  boot_cmd_drive #(.ROW_W(ROW_W)) u_drive (
    .step(step), .fire(fire), .mr_word(mr_word), .emr1_word(emr1_word),
    .emr2_word(emr2_word), .emr3_word(emr3_word), .cke(cke), .odt(odt),
    .pins(pins), .ba(ba), .addr(addr), .ready(ready)
  );

  assign {cs_n, ras_n, cas_n, we_n} = pins;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int T_MRD = 2,
  parameter int T_RFC = 26,
  parameter int T_DLL = 200
) (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic [2:0] ocd_bits,
  input logic       ready,
  input logic       ev_dll_mrs
);
  localparam int SAT = 1 << 24;

  logic [3:0] pins;
  logic       is_mode, is_ref, is_ocd_dflt;
  int         since_mode, since_ref, since_dll;
  logic       seen_mode, seen_ref, seen_dll;

  assign pins        = {cs_n, ras_n, cas_n, we_n};
  assign is_mode     = (pins == 4'b0000);
  assign is_ref      = (pins == 4'b0001);
  assign is_ocd_dflt = is_mode && (ba == 2'd1) && (ocd_bits == 3'b111);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_mode <= 0; since_ref <= 0; since_dll <= 0;
      seen_mode  <= 1'b0; seen_ref <= 1'b0; seen_dll <= 1'b0;
    end else begin
      if (is_mode) begin since_mode <= 1; seen_mode <= 1'b1; end
      else if (since_mode < SAT) since_mode <= since_mode + 1;
      if (is_ref) begin since_ref <= 1; seen_ref <= 1'b1; end
      else if (since_ref < SAT) since_ref <= since_ref + 1;
      if (ev_dll_mrs) begin since_dll <= 1; seen_dll <= 1'b1; end
      else if (since_dll < SAT) since_dll <= since_dll + 1;
    end
  end

  p_cke_low_nop_r2: assert property (@(posedge clk) disable iff (rst)
    !cke |-> pins == 4'b0111);
  p_cke_stays_r2: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);
  p_mode_space_r4: assert property (@(posedge clk) disable iff (rst)
    (is_mode && seen_mode) |-> since_mode >= T_MRD);
  p_ref_space_r7: assert property (@(posedge clk) disable iff (rst)
    (is_ref && seen_ref) |-> since_ref >= T_RFC);
  p_ocd_gap_r9: assert property (@(posedge clk) disable iff (rst)
    is_ocd_dflt |-> (seen_dll && since_dll >= T_DLL));
  p_ready_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  p_ready_nop_r10: assert property (@(posedge clk) disable iff (rst)
    ready |-> (pins == 4'b0111 && cke));
endmodule

bind ddr2_boot_seq boot_seq_chk #(.T_MRD(T_MRD), .T_RFC(T_RFC), .T_DLL(T_DLL)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .ocd_bits(addr[9:7]), .ready(ready), .ev_dll_mrs(ev_dll_mrs)
);

// File: tb/ddr2_boot_seq_tb.sv
`timescale 1ns/1ps
module ddr2_boot_seq_tb;
  localparam int T_PWR = 20, T_NOP = 8, T_RP = 3, T_MRD = 2, T_RFC = 5;
  localparam int T_DLL = 40, N_REF = 2, ROW_W = 14;

  localparam int P_PRE1 = T_PWR + T_NOP;
  localparam int P_EMR2 = P_PRE1 + T_RP;
  localparam int P_EMR3 = P_EMR2 + T_MRD;
  localparam int P_EMR1 = P_EMR3 + T_MRD;
  localparam int P_DLL  = P_EMR1 + T_MRD;
  localparam int P_PRE2 = P_DLL + T_MRD;
  localparam int P_REF0 = P_PRE2 + T_RP;
  localparam int P_MRF  = P_REF0 + N_REF * T_RFC;
  localparam int P_OCD  = (P_MRF + T_MRD > P_DLL + T_DLL) ? P_MRF + T_MRD : P_DLL + T_DLL;
  localparam int P_OCDX = P_OCD + T_MRD;
  localparam int P_RDY  = P_OCDX + T_MRD;

  logic clk = 1'b0, rst = 1'b1;
  logic [ROW_W-1:0] mr_word = '0, emr1_word = '0, emr2_word = '0, emr3_word = '0;
  logic cke, odt, cs_n, ras_n, cas_n, we_n, ready;
  logic [1:0] ba;
  logic [ROW_W-1:0] addr;

  int total = 0, bad = 0, cyc = 0;
  logic mon_on = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  ddr2_boot_seq #(.T_PWR(T_PWR), .T_NOP(T_NOP), .T_RP(T_RP), .T_MRD(T_MRD),
    .T_RFC(T_RFC), .T_DLL(T_DLL), .N_REF(N_REF), .ROW_W(ROW_W)) u_dut (
    .clk(clk), .rst(rst), .mr_word(mr_word), .emr1_word(emr1_word),
    .emr2_word(emr2_word), .emr3_word(emr3_word), .cke(cke), .odt(odt),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
    .addr(addr), .ready(ready));

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic compare(input string tag, input logic e_cke, input logic [3:0] e_cmd,
                         input logic [1:0] e_ba, input logic [ROW_W-1:0] e_addr,
                         input logic e_rdy);
    total++;
    if ({cke, odt, cs_n, ras_n, cas_n, we_n, ba, addr, ready} !==
        {e_cke, 1'b0, e_cmd, e_ba, e_addr, e_rdy}) begin
      bad++;
      $display("FAIL %s cyc=%0d actual cke=%b odt=%b cmd=%b ba=%0d addr=%h rdy=%b expected cke=%b odt=0 cmd=%b ba=%0d addr=%h rdy=%b",
               tag, cyc, cke, odt, {cs_n, ras_n, cas_n, we_n}, ba, addr, ready,
               e_cke, e_cmd, e_ba, e_addr, e_rdy);
    end
  endtask

  // expected pins per cycle since reset release, derived from the requirements
  task automatic check_cycle();
    int c;
    string tag;
    logic [3:0] e_cmd;
    logic [1:0] e_ba;
    logic [ROW_W-1:0] e_addr;
    c = cyc;
    e_cmd = 4'b0111; e_ba = 2'd0; e_addr = '0;
    tag = (c < P_PRE1) ? "R2" : (c >= P_RDY) ? "R10" : "R11";
    if (c == P_PRE1) begin tag = "R3"; e_cmd = 4'b0010; e_addr = 14'h0400; end
    else if (c == P_EMR2) begin tag = "R4"; e_cmd = 4'b0000; e_ba = 2; e_addr = emr2_word; end
    else if (c == P_EMR3) begin tag = "R4"; e_cmd = 4'b0000; e_ba = 3; e_addr = emr3_word; end
    else if (c == P_EMR1) begin tag = "R5"; e_cmd = 4'b0000; e_ba = 1; e_addr = emr1_word & ~14'h0381; end
    else if (c == P_DLL)  begin tag = "R6"; e_cmd = 4'b0000; e_ba = 0; e_addr = mr_word | 14'h0100; end
    else if (c == P_PRE2) begin tag = "R7"; e_cmd = 4'b0010; e_addr = 14'h0400; end
    else if (c >= P_REF0 && c < P_MRF && (c - P_REF0) % T_RFC == 0) begin tag = "R7"; e_cmd = 4'b0001; end
    else if (c == P_MRF)  begin tag = "R8"; e_cmd = 4'b0000; e_ba = 0; e_addr = mr_word & ~14'h0100; end
    else if (c == P_OCD)  begin tag = "R9"; e_cmd = 4'b0000; e_ba = 1; e_addr = (emr1_word & ~14'h0381) | 14'h0380; end
    else if (c == P_OCDX) begin tag = "R10"; e_cmd = 4'b0000; e_ba = 1; e_addr = emr1_word & ~14'h0381; end
    compare(tag, c >= T_PWR, e_cmd, e_ba, e_addr, c >= P_RDY);
  endtask

  always @(negedge clk) if (mon_on && !rst) check_cycle();

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    @(negedge clk);
    compare("R1", 1'b0, 4'b0111, 2'd0, '0, 1'b0);
    tick();
    rst = 1'b0;
  endtask

  task automatic run_until(input int last);
    mon_on = 1'b1;
    while (cyc < last) tick();
    mon_on = 1'b0;
  endtask

  initial begin
    tick();
    mr_word = 14'h0163; emr1_word = 14'h3FFF; emr2_word = 14'h0000; emr3_word = 14'h0000;
    do_reset();
    run_until(P_RDY + 12);

    mr_word = 14'h0052; emr1_word = 14'h0044; emr2_word = 14'h0080; emr3_word = 14'h1234;
    do_reset();
    run_until(P_REF0 + 2);   // R1: interrupt during refresh phase
    do_reset();
    run_until(P_RDY + 6);

    mr_word = 14'h3EFF; emr1_word = 14'h0000; emr2_word = 14'h3FFF; emr3_word = 14'h2AAA;
    do_reset();
    run_until(P_RDY + 6);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule